// File: doc/BRIEF.md
# Opcode-Aligned 16-bit Arithmetic Logic Unit

This block is the combinational arithmetic and logic unit of a small load/store processor. It takes two 16-bit operands and a 4-bit select and returns a 16-bit result and one flag. No clock and no stored state are involved: both outputs are pure functions of the present inputs.

The select codes are the same as the processor's 4-bit instruction opcodes, so the instruction decoder can feed the opcode field to `sel` without translating it. The block adds, subtracts, multiplies (low half of the product), shifts right logically, and forms OR, AND, XOR and the inverse. It also has a compare-for-equality operation that raises the flag. For every other computing operation the flag reports a zero result. Select codes that the processor spends on loads, stores, branches and immediates leave the unit quiet.

Top module: `opcode_alu`

## Requirements
- R1: sel 4'b0011 gives result = opA + opB and sel 4'b0100 gives result = opA - opB, both taken modulo 2^16.
- R2: sel 4'b0101 gives opA | opB, sel 4'b0110 gives opA & opB and sel 4'b1000 gives opA ^ opB, bit by bit.
- R3: sel 4'b0111 gives the bitwise inverse of opA, and opB has no effect on result or flag.
- R4: sel 4'b1010 shifts opA right logically (zero fill) by opB[3:0], a shift of 0 to 15 places, and opB[15:4] have no effect.
- R5: sel 4'b1011 gives the low 16 bits of the unsigned product opA * opB.
- R6: sel 4'b1100 drives flag to 1 exactly when opA equals opB, and drives result to 16'h0000.
- R7: for each select code named in R1 to R5, flag is 1 exactly when the 16-bit result is 16'h0000.
- R8: the unused select codes 4'b0000, 4'b0001, 4'b0010, 4'b1001, 4'b1101, 4'b1110 and 4'b1111 give result 16'h0000 and flag 0 for any operands.
- R9: result and flag depend only on the present inputs: the same inputs give the same outputs whatever came before, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand; the value shifted, inverted or compared |
| opB | input | 16 | Second operand; low 4 bits are the shift amount for a right shift |
| sel | input | 4 | Operation select, encoded as the processor's opcode |
| result | output | 16 | Operation result; zero on compare and on unused codes |
| flag | output | 1 | Equality on compare, zero-result on computing operations, 0 otherwise |

## Verification
The flag has two meanings that can land on the same input pair. A zero result from a computing operation and an equality from a compare both look the same at the flag. The bench sends equal operands, and operands whose sum, difference, product or shift comes out zero, through every select code one after another. It judges each flag against the meaning the applied code gives it: the same pair must raise the flag under compare and under subtract, but not under add unless the sum wraps to zero. Random pairs per code, plus the corner values 0x0000, 0xFFFF, 0x8000 and 0x7FFF, are compared against arithmetic done in the bench.

// File: rtl/opcode_alu_pkg.sv
package opcode_alu_pkg;

  localparam int SEL_W = 4;

  // select codes, equal to the processor's instruction opcodes
  localparam logic [SEL_W-1:0] SEL_ADD = 4'b0011;
  localparam logic [SEL_W-1:0] SEL_SUB = 4'b0100;
  localparam logic [SEL_W-1:0] SEL_OR  = 4'b0101;
  localparam logic [SEL_W-1:0] SEL_AND = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_NOT = 4'b0111;
  localparam logic [SEL_W-1:0] SEL_XOR = 4'b1000;
  localparam logic [SEL_W-1:0] SEL_SHR = 4'b1010;
  localparam logic [SEL_W-1:0] SEL_MUL = 4'b1011;
  localparam logic [SEL_W-1:0] SEL_CMP = 4'b1100;

  // indices of the computing operations in the pick vector
  localparam int PICK_ADD = 0;
  localparam int PICK_SUB = 1;
  localparam int PICK_OR  = 2;
  localparam int PICK_AND = 3;
  localparam int PICK_NOT = 4;
  localparam int PICK_XOR = 5;
  localparam int PICK_SHR = 6;
  localparam int PICK_MUL = 7;
  localparam int PICK_CNT = 8;

  typedef struct packed {
    logic                writesResult;  // a computing op drives result
    logic                isCompare;     // equality compare owns the flag
    logic [PICK_CNT-1:0] pick;          // one-hot choice of candidate
  } strobes_t;

endpackage

// File: rtl/opcode_alu_ctrl.sv
module opcode_alu_ctrl
  import opcode_alu_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output strobes_t         strobes
);

  always_comb begin
    strobes = '0;
    unique case (sel)
      SEL_ADD: strobes.pick[PICK_ADD] = 1'b1;
      SEL_SUB: strobes.pick[PICK_SUB] = 1'b1;
      SEL_OR:  strobes.pick[PICK_OR]  = 1'b1;
      SEL_AND: strobes.pick[PICK_AND] = 1'b1;
      SEL_NOT: strobes.pick[PICK_NOT] = 1'b1;
      SEL_XOR: strobes.pick[PICK_XOR] = 1'b1;
      SEL_SHR: strobes.pick[PICK_SHR] = 1'b1;
      SEL_MUL: strobes.pick[PICK_MUL] = 1'b1;
      SEL_CMP: strobes.isCompare      = 1'b1;
      default: strobes = '0;
    endcase
    strobes.writesResult = |strobes.pick;
  end

endmodule

// File: rtl/opcode_alu_dp.sv
module opcode_alu_dp
  import opcode_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobes_t         strobes,
  output logic [WIDTH-1:0] result,
  output logic             flag
);

  localparam int SHAMT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] cand [PICK_CNT];
  logic [SHAMT_W-1:0] shAmt;
  logic eqOperands;
  logic resultZero;

  assign shAmt = opB[SHAMT_W-1:0];

  always_comb begin
    cand[PICK_ADD] = opA + opB;
    cand[PICK_SUB] = opA - opB;
    cand[PICK_OR]  = opA | opB;
    cand[PICK_AND] = opA & opB;
    cand[PICK_NOT] = ~opA;
    cand[PICK_XOR] = opA ^ opB;
    cand[PICK_SHR] = opA >> shAmt;
    cand[PICK_MUL] = opA * opB;
  end

  // AND-OR selection: the pick vector is one-hot or empty
  always_comb begin
    result = '0;
    for (int i = 0; i < PICK_CNT; i++) begin
      result = result | (cand[i] & {WIDTH{strobes.pick[i]}});
    end
  end

  assign eqOperands = (opA == opB);
  assign resultZero = ~|result;

  always_comb begin
    flag = 1'b0;
    if (strobes.isCompare)         flag = eqOperands;
    else if (strobes.writesResult) flag = resultZero;
  end

endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
  import opcode_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] result,
  output logic             flag
);

  strobes_t strobes;

  opcode_alu_ctrl u_ctrl (
    .sel     (sel),
    .strobes (strobes)
  );

  opcode_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .flag    (flag)
  );

endmodule

// File: rtl/opcode_alu_chk.sv
module opcode_alu_chk
  import opcode_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [SEL_W-1:0] sel,
  input logic [WIDTH-1:0] result,
  input logic             flag,
  input strobes_t         strobes
);

  logic computing;
  logic unusedCode;

  assign computing = (sel == SEL_ADD) || (sel == SEL_SUB) || (sel == SEL_OR) ||
                     (sel == SEL_AND) || (sel == SEL_NOT) || (sel == SEL_XOR) ||
                     (sel == SEL_SHR) || (sel == SEL_MUL);
  assign unusedCode = !computing && (sel != SEL_CMP);

  always_comb begin
    if (!$isunknown({opA, opB, sel})) begin
      assert_pick_onehot_R9: assert ($onehot0(strobes.pick));
      assert_inverse_R3: assert (!(sel == SEL_NOT) || (result == ~opA));
      assert_cmp_result_R6: assert (!(sel == SEL_CMP) || (result == '0));
      assert_cmp_flag_R6: assert (!(sel == SEL_CMP) || (flag == (opA == opB)));
      assert_zero_flag_R7: assert (!computing || (flag == (result == '0)));
      assert_unused_quiet_R8: assert (!unusedCode || (result == '0 && !flag));
    end
  end

endmodule

bind opcode_alu opcode_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opA     (opA),
  .opB     (opB),
  .sel     (sel),
  .result  (result),
  .flag    (flag),
  .strobes (strobes)
);

// File: tb/sim_opcode_alu.sv
`timescale 1ns/1ps
module sim_opcode_alu;

  logic clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [3:0]  sel = '0;
  logic [15:0] result;
  logic        flag;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;  // 125 MHz

  opcode_alu u0 (.opA(opA), .opB(opB), .sel(sel), .result(result), .flag(flag));

  function automatic string reqOf(input logic [3:0] s);
    case (s)
      4'd3, 4'd4:  reqOf = "R1";
      4'd5, 4'd6, 4'd8: reqOf = "R2";
      4'd7:        reqOf = "R3";
      4'd10:       reqOf = "R4";
      4'd11:       reqOf = "R5";
      4'd12:       reqOf = "R6";
      default:     reqOf = "R8";
    endcase
  endfunction

  task automatic refModel(input logic [3:0] s, input logic [15:0] a, input logic [15:0] b,
                          output logic [15:0] r, output logic f);
    logic [31:0] wide;
    r = 16'h0000;
    f = 1'b0;
    case (s)
      4'd3:  begin wide = {16'h0, a} + {16'h0, b}; r = wide[15:0]; end
      4'd4:  begin wide = 32'h10000 + {16'h0, a} - {16'h0, b}; r = wide[15:0]; end
      4'd5:  r = a | b;
      4'd6:  r = a & b;
      4'd7:  r = a ^ 16'hFFFF;
      4'd8:  r = a ^ b;
      4'd10: begin wide = {16'h0, a} / (32'd1 << b[3:0]); r = wide[15:0]; end
      4'd11: begin wide = {16'h0, a} * {16'h0, b}; r = wide[15:0]; end
      default: r = 16'h0000;
    endcase
    if (s == 4'd12) f = (a == b);
    else if ((s >= 4'd3 && s <= 4'd8) || s == 4'd10 || s == 4'd11) f = (r == 16'h0000);  // R7
  endtask

  task automatic applyVec(input logic [3:0] s, input logic [15:0] a, input logic [15:0] b,
                          input string tag);
    logic [15:0] expR;
    logic expF;
    @(posedge clk);
    #1;
    sel = s; opA = a; opB = b;
    refModel(s, a, b, expR, expF);
    @(negedge clk);
    vectors++;
    if (result !== expR || flag !== expF) begin
      miscompares++;
      $display("FAIL %s sel=%b a=%h b=%h result=%h flag=%b expected result=%h flag=%b",
               tag, s, a, b, result, flag, expR, expF);
    end
  endtask

  logic [15:0] corner [5] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001};

  initial begin
    #(8 * 190000);
    miscompares++;
    $display("FAIL R9 watchdog expired after %0d vectors", vectors);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // idle state: all-zero inputs are an unused code (R8)
    applyVec(4'd0, 16'h0000, 16'h0000, "R8 idle");

    for (int s = 0; s < 16; s++) begin
      string t = reqOf(4'(s));
      foreach (corner[i]) foreach (corner[j])
        applyVec(4'(s), corner[i], corner[j], t);
      for (int n = 0; n < 1000; n++)
        applyVec(4'(s), 16'($urandom), 16'($urandom), t);
      for (int n = 0; n < 40; n++) begin
        logic [15:0] v = 16'($urandom);
        applyVec(4'(s), v, v, {t, " equal"});
      end
    end

    // R4: every shift amount, upper bits of opB set and clear
    for (int k = 0; k < 16; k++) begin
      applyVec(4'd10, 16'hB5A3, 16'(k), "R4 amount");
      applyVec(4'd10, 16'hB5A3, 16'hFFF0 | 16'(k), "R4 high bits ignored");
    end
    // R3: opB ignored
    applyVec(4'd7, 16'h1234, 16'h0000, "R3 b ignored");
    applyVec(4'd7, 16'h1234, 16'hFFFF, "R3 b ignored");
    // R7 vs R6: same pair through several meanings of the flag
    applyVec(4'd12, 16'h4C4C, 16'h4C4C, "R6 equal");
    applyVec(4'd4,  16'h4C4C, 16'h4C4C, "R7 sub zero");
    applyVec(4'd3,  16'h4C4C, 16'h4C4C, "R7 add nonzero");
    applyVec(4'd3,  16'h8000, 16'h8000, "R7 add wraps to zero");
    applyVec(4'd11, 16'h0100, 16'h0100, "R5 product wraps to zero");
    applyVec(4'd12, 16'h4C4C, 16'h4C4D, "R6 unequal");
    // R9: repeat a vector after unrelated traffic
    for (int r = 0; r < 8; r++) begin
      applyVec(4'd11, 16'h3A7F, 16'h00C9, "R9 before");
      applyVec(4'(r + 8), 16'($urandom), 16'($urandom), reqOf(4'(r + 8)));
      applyVec(4'd11, 16'h3A7F, 16'h00C9, "R9 repeat");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule